// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

This block holds a small set of recent virtual-to-physical page translations so that most memory accesses avoid a page-table lookup. A lookup presents a virtual address, the requested access kind (write or read, user or supervisor) and the address space identifier of the running context. The block answers in the same cycle. It reports a hit or a miss and, on a hit, either a permitted access with the physical address or a protection fault.

After a miss, a separate walker fetches the translation and writes it through the fill port. The access is then retried and hits. Each entry carries a tag for its address space, so translations from several contexts can live side by side. Entries marked global match in every context. A flush input empties the whole cache, for use on a context switch when tags are not relied on. When every slot is occupied, a new translation replaces the slot that has gone unused the longest.

Top module: `xlat_cache`

## Requirements
- R1: On a permitted hit, `access_o` is 1 and `pa_o` equals the cached frame number shifted left by 12, ORed with the low 12 bits of `lookup_va_i`. Pages are 4 KB, and bits 31:12 of the address are the page number.
- R2: An entry matches only if it is valid, its page number equals the lookup page number, and either its tag equals `cur_asid_i` or its global flag is set.
- R3: While `lookup_valid_i` is 1, exactly one of `hit_o` and `miss_o` is 1, and `miss_o` is 1 when no entry matches. While `lookup_valid_i` is 0, both are 0. After reset, every lookup misses.
- R4: A hit faults when a write targets an entry whose write-permit bit is 0, or when a user access targets an entry whose user-permit bit is 0. On a fault, `fault_o` is 1, `access_o` is 0 and `pa_o` is 0.
- R5: On a hit, `dirty_o` reports the dirty bit stored with the matching entry. It is 0 on a miss.
- R6: `flush_i` invalidates every entry at the next clock edge. A fill presented in the same cycle is discarded.
- R7: Eight distinct translations can be held at once, and all of them hit.
- R8: Every hit and every fill makes its entry the most recently used. A fill into a full cache evicts the least recently used entry.
- R9: A fill whose page number and tag equal those of a valid entry overwrites that entry and allocates no new slot.
- R10: Lookups are combinational on the stored entries. A fill is visible to lookups from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request present |
| lookup_va_i | input | 32 | Virtual address to translate |
| lookup_write_i | input | 1 | Access is a write |
| lookup_user_i | input | 1 | Access comes from user mode |
| cur_asid_i | input | 8 | Tag of the running context |
| hit_o | output | 1 | Matching entry found |
| miss_o | output | 1 | No matching entry |
| fault_o | output | 1 | Hit with a forbidden access |
| access_o | output | 1 | Permitted access, `pa_o` valid |
| pa_o | output | 32 | Physical address |
| dirty_o | output | 1 | Dirty bit of the hit entry |
| fill_valid_i | input | 1 | Insert a translation |
| fill_vpn_i | input | 20 | Page number to insert |
| fill_pfn_i | input | 20 | Frame number to insert |
| fill_asid_i | input | 8 | Tag to insert |
| fill_global_i | input | 1 | Entry matches any tag |
| fill_dirty_i | input | 1 | Dirty bit to store |
| fill_wr_ok_i | input | 1 | Writes permitted |
| fill_usr_ok_i | input | 1 | User accesses permitted |
| flush_i | input | 1 | Invalidate all entries |

## Verification
The hardest case to reach is an eviction whose victim differs from plain insertion order. The eight slots must all be full, and the recency order must have been reshuffled by a hit before the ninth fill arrives. The stimulus fills all slots in sequence and then hits the oldest entry. It then inserts a new page and checks that the second-oldest page is gone while the refreshed page survives. A repeated fill of a resident page follows, which checks that no further slot is consumed.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef struct packed {
    logic wr_ok;
    logic usr_ok;
  } perm_t;

  function automatic logic perm_fault(perm_t p, logic is_wr, logic is_usr);
    return (is_wr && !p.wr_ok) || (is_usr && !p.usr_ok);
  endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]      valid_i,
  input  logic [N-1:0]      glb_i,
  input  logic [VPN_W-1:0]  vpn_i  [N],
  input  logic [ASID_W-1:0] asid_i [N],
  input  logic [VPN_W-1:0]  look_vpn_i,
  input  logic [ASID_W-1:0] look_asid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  output logic [N-1:0]      hit_vec_o,
  output logic [N-1:0]      same_vec_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec_o[g]  = valid_i[g] && (vpn_i[g] == look_vpn_i) &&
                           (glb_i[g] || (asid_i[g] == look_asid_i));
    assign same_vec_o[g] = valid_i[g] && (vpn_i[g] == fill_vpn_i) &&
                           (asid_i[g] == fill_asid_i);
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_en_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [N-1:0]     valid_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] age_q [N];
  logic [N-1:0]     seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en_i) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx_i)             age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i])   age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  // free slot first (lowest index), else the oldest
  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && !valid_i[i]) begin
        victim_o = IDX_W'(i);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++)
        if (age_q[i] == IDX_W'(N-1)) victim_o = IDX_W'(i);
    end
  end

  always_comb begin
    seen = '0;
    for (int i = 0; i < N; i++) seen[age_q[i]] = 1'b1;
  end

  // R8
  age_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) &seen);

  // R8
  touch_age_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_en_i |=> age_q[$past(touch_idx_i)] == '0);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int OFFS_W = 12,
  localparam int VA_W  = VPN_W + OFFS_W,
  localparam int PA_W  = PFN_W + OFFS_W,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [VA_W-1:0]   lookup_va_i,
  input  logic              lookup_write_i,
  input  logic              lookup_user_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              fault_o,
  output logic              access_o,
  output logic [PA_W-1:0]   pa_o,
  output logic              dirty_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_global_i,
  input  logic              fill_dirty_i,
  input  logic              fill_wr_ok_i,
  input  logic              fill_usr_ok_i,
  input  logic              flush_i
);
  import xlat_pkg::*;

  logic [N-1:0]      valid_q, glb_q, dirty_q;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  logic [ASID_W-1:0] asid_q [N];
  perm_t             perm_q [N];

  logic [VPN_W-1:0]  va_vpn;
  logic [OFFS_W-1:0] va_off;
  logic [N-1:0]      hit_vec, same_vec;
  logic [IDX_W-1:0]  hit_idx, same_idx, victim_idx, alloc_idx, touch_idx;
  logic              any_hit, any_same, fill_go, touch_en;

  assign va_vpn = lookup_va_i[VA_W-1:OFFS_W];
  assign va_off = lookup_va_i[OFFS_W-1:0];

  xlat_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .valid_i     (valid_q),
    .glb_i       (glb_q),
    .vpn_i       (vpn_q),
    .asid_i      (asid_q),
    .look_vpn_i  (va_vpn),
    .look_asid_i (cur_asid_i),
    .fill_vpn_i  (fill_vpn_i),
    .fill_asid_i (fill_asid_i),
    .hit_vec_o   (hit_vec),
    .same_vec_o  (same_vec)
  );

  // lowest index wins on multiple matches
  always_comb begin
    hit_idx  = '0;
    same_idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (hit_vec[i])  hit_idx  = IDX_W'(i);
      if (same_vec[i]) same_idx = IDX_W'(i);
    end
  end

  assign any_hit  = |hit_vec;
  assign any_same = |same_vec;

  assign hit_o    = lookup_valid_i && any_hit;
  assign miss_o   = lookup_valid_i && !any_hit;
  assign fault_o  = hit_o && perm_fault(perm_q[hit_idx], lookup_write_i, lookup_user_i);
  assign access_o = hit_o && !fault_o;
  assign pa_o     = access_o ? {pfn_q[hit_idx], va_off} : '0;
  assign dirty_o  = hit_o && dirty_q[hit_idx];

  assign fill_go   = fill_valid_i && !flush_i;
  assign alloc_idx = any_same ? same_idx : victim_idx;
  assign touch_en  = fill_go || (hit_o && !flush_i);
  assign touch_idx = fill_go ? alloc_idx : hit_idx;

  xlat_lru #(.N(N)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_en_i  (touch_en),
    .touch_idx_i (touch_idx),
    .valid_i     (valid_q),
    .victim_o    (victim_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      glb_q   <= '0;
      dirty_q <= '0;
      for (int i = 0; i < N; i++) begin
        vpn_q[i]  <= '0;
        pfn_q[i]  <= '0;
        asid_q[i] <= '0;
        perm_q[i] <= '0;
      end
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (fill_go) begin
      valid_q[alloc_idx] <= 1'b1;
      glb_q[alloc_idx]   <= fill_global_i;
      dirty_q[alloc_idx] <= fill_dirty_i;
      vpn_q[alloc_idx]   <= fill_vpn_i;
      pfn_q[alloc_idx]   <= fill_pfn_i;
      asid_q[alloc_idx]  <= fill_asid_i;
      perm_q[alloc_idx]  <= '{wr_ok: fill_wr_ok_i, usr_ok: fill_usr_ok_i};
    end
  end

  // R6
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);

  // R10
  fill_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_go |=> (!(lookup_valid_i && va_vpn == $past(fill_vpn_i) &&
                   cur_asid_i == $past(fill_asid_i)) || hit_o));

  // R4
  fault_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!access_o && pa_o == '0));

  // R1
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_o |-> pa_o[OFFS_W-1:0] == lookup_va_i[OFFS_W-1:0]);

  // R3
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |-> (!hit_o && !miss_o));
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lookup_valid_i = 1'b0;
  logic [31:0] lookup_va_i = '0;
  logic        lookup_write_i = 1'b0, lookup_user_i = 1'b0;
  logic [7:0]  cur_asid_i = '0;
  logic        hit_o, miss_o, fault_o, access_o, dirty_o;
  logic [31:0] pa_o;
  logic        fill_valid_i = 1'b0;
  logic [19:0] fill_vpn_i = '0, fill_pfn_i = '0;
  logic [7:0]  fill_asid_i = '0;
  logic        fill_global_i = 1'b0, fill_dirty_i = 1'b0;
  logic        fill_wr_ok_i = 1'b0, fill_usr_ok_i = 1'b0;
  logic        flush_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xlat_cache uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lookup_valid_i(lookup_valid_i), .lookup_va_i(lookup_va_i),
    .lookup_write_i(lookup_write_i), .lookup_user_i(lookup_user_i),
    .cur_asid_i(cur_asid_i),
    .hit_o(hit_o), .miss_o(miss_o), .fault_o(fault_o), .access_o(access_o),
    .pa_o(pa_o), .dirty_o(dirty_o),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_pfn_i(fill_pfn_i),
    .fill_asid_i(fill_asid_i), .fill_global_i(fill_global_i),
    .fill_dirty_i(fill_dirty_i), .fill_wr_ok_i(fill_wr_ok_i),
    .fill_usr_ok_i(fill_usr_ok_i), .flush_i(flush_i)
  );

  typedef struct packed {
    logic [19:0] vpn;
    logic [7:0]  asid;
    logic        wr;
    logic        us;
    logic [11:0] off;
    logic        e_hit;
    logic        e_fault;
    logic        e_dirty;
    logic [19:0] e_pfn;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{20'h00010, 8'd1, 1'b0, 1'b1, 12'h123, 1'b1, 1'b0, 1'b1, 20'h0AAAA}, // R1 R5
    '{20'h00010, 8'd2, 1'b0, 1'b1, 12'h123, 1'b0, 1'b0, 1'b0, 20'h00000}, // R2 other tag
    '{20'h00020, 8'd1, 1'b1, 1'b0, 12'h004, 1'b1, 1'b1, 1'b0, 20'h0BBBB}, // R4 write to read-only
    '{20'h00020, 8'd1, 1'b0, 1'b1, 12'hFFF, 1'b1, 1'b0, 1'b0, 20'h0BBBB}, // R1
    '{20'h00030, 8'd2, 1'b0, 1'b1, 12'h010, 1'b1, 1'b1, 1'b0, 20'h0CCCC}, // R4 user to supervisor page
    '{20'h00030, 8'd2, 1'b1, 1'b0, 12'h010, 1'b1, 1'b0, 1'b0, 20'h0CCCC}, // R4 supervisor write ok
    '{20'h00040, 8'd9, 1'b1, 1'b1, 12'h800, 1'b1, 1'b0, 1'b0, 20'h0DDDD}, // R2 global
    '{20'h00050, 8'd1, 1'b0, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 20'h00000}  // R3 miss
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] pfn, logic [7:0] asid,
                      logic glb, logic dty, logic wr, logic us);
    @(negedge clk);
    lookup_valid_i = 1'b0;
    fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_pfn_i = pfn; fill_asid_i = asid;
    fill_global_i = glb; fill_dirty_i = dty; fill_wr_ok_i = wr; fill_usr_ok_i = us;
    @(posedge clk);
    #1 fill_valid_i = 1'b0;
  endtask

  task automatic look(logic [19:0] vpn, logic [7:0] asid, logic wr, logic us, logic [11:0] off);
    @(negedge clk);
    lookup_valid_i = 1'b1; lookup_va_i = {vpn, off}; cur_asid_i = asid;
    lookup_write_i = wr; lookup_user_i = us;
    #2;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R3 reset state and idle
    #2;
    chk("R3", "idle hit", {31'd0, hit_o}, 32'd0);
    chk("R3", "idle miss", {31'd0, miss_o}, 32'd0);
    look(20'h00010, 8'd1, 1'b0, 1'b0, 12'h0);
    chk("R3", "reset miss", {31'd0, miss_o}, 32'd1);

    // R10 fills visible next cycle
    fill(20'h00010, 20'h0AAAA, 8'd1, 1'b0, 1'b1, 1'b1, 1'b1);
    fill(20'h00020, 20'h0BBBB, 8'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    fill(20'h00030, 20'h0CCCC, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    fill(20'h00040, 20'h0DDDD, 8'd5, 1'b1, 1'b0, 1'b1, 1'b1);

    for (int v = 0; v < NV; v++) begin
      look(VECS[v].vpn, VECS[v].asid, VECS[v].wr, VECS[v].us, VECS[v].off);
      chk("R2", "hit", {31'd0, hit_o}, {31'd0, VECS[v].e_hit});
      chk("R3", "miss", {31'd0, miss_o}, {31'd0, !VECS[v].e_hit});
      chk("R4", "fault", {31'd0, fault_o}, {31'd0, VECS[v].e_fault});
      chk("R1", "pa", pa_o,
          (VECS[v].e_hit && !VECS[v].e_fault) ? {VECS[v].e_pfn, VECS[v].off} : 32'd0);
      chk("R5", "dirty", {31'd0, dirty_o}, {31'd0, VECS[v].e_dirty});
    end

    // R6 flush wins over same-cycle fill
    @(negedge clk);
    lookup_valid_i = 1'b0;
    flush_i = 1'b1; fill_valid_i = 1'b1; fill_vpn_i = 20'h00200;
    fill_pfn_i = 20'h00999; fill_asid_i = 8'd1; fill_global_i = 1'b0;
    @(posedge clk);
    #1 flush_i = 1'b0; fill_valid_i = 1'b0;
    look(20'h00010, 8'd1, 1'b0, 1'b0, 12'h0);
    chk("R6", "flushed entry", {31'd0, miss_o}, 32'd1);
    look(20'h00040, 8'd5, 1'b0, 1'b0, 12'h0);
    chk("R6", "flushed global", {31'd0, miss_o}, 32'd1);
    look(20'h00200, 8'd1, 1'b0, 1'b0, 12'h0);
    chk("R6", "discarded fill", {31'd0, miss_o}, 32'd1);

    // R8 fill all slots, refresh the oldest, then evict
    for (int i = 0; i < 8; i++)
      fill(20'h00100 + 20'(i), 20'h01000 + 20'(i), 8'd3, 1'b0, 1'b0, 1'b1, 1'b1);
    look(20'h00100, 8'd3, 1'b0, 1'b0, 12'h0);
    chk("R8", "refresh hit", {31'd0, hit_o}, 32'd1);
    fill(20'h00108, 20'h01008, 8'd3, 1'b0, 1'b0, 1'b1, 1'b1);
    look(20'h00101, 8'd3, 1'b0, 1'b0, 12'h0);
    chk("R8", "victim gone", {31'd0, miss_o}, 32'd1);
    look(20'h00100, 8'd3, 1'b0, 1'b0, 12'h0);
    chk("R8", "refreshed kept", {31'd0, hit_o}, 32'd1);

    // R7 eight translations resident
    for (int i = 2; i <= 8; i++) begin
      look(20'h00100 + 20'(i), 8'd3, 1'b0, 1'b0, 12'h055);
      chk("R7", "resident pa", pa_o, {20'h01000 + 20'(i), 12'h055});
    end

    // R9 refill of a resident page overwrites in place
    fill(20'h00103, 20'h00777, 8'd3, 1'b0, 1'b1, 1'b1, 1'b1);
    look(20'h00103, 8'd3, 1'b0, 1'b0, 12'h0AB);
    chk("R9", "overwritten pa", pa_o, {20'h00777, 12'h0AB});
    chk("R9", "overwritten dirty", {31'd0, dirty_o}, 32'd1);
    for (int i = 0; i <= 8; i++) begin
      if (i != 1) begin
        look(20'h00100 + 20'(i), 8'd3, 1'b0, 1'b0, 12'h0);
        chk("R9", "no slot lost", {31'd0, hit_o}, 32'd1);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule